// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block forms the byte address of a single load or store and the value the base register should take afterwards. A request carries a 32-bit base, a 12-bit unsigned immediate, a 32-bit register offset with a 5-bit left-shift amount, and several control bits. The control bits choose whether the offset is added or subtracted, and whether it comes from the immediate or the register. They also choose one of three indexing behaviours: pre-index with the base kept, pre-index with the base replaced, or post-index with the base replaced.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel through one register stage. A request is taken on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or its result is being taken in the same cycle. A result stays on the output, unchanged, until a cycle where `out_valid` and `out_ready` are both high. Nothing is dropped and nothing is duplicated. All arithmetic wraps modulo 2^32, and no overflow indication exists.

Top module: `lsu_addr_gen`

## Requirements
- R1: With `in_use_reg`=0 the offset is `in_imm` zero-extended to 32 bits (an immediate of 0xFFF adds 4095, never a negative value).
- R2: With `in_use_reg`=1 the offset is `in_ofs_reg` shifted left by `in_shamt` (0..31), keeping the low 32 bits; with `in_use_reg`=0 both `in_shamt` and `in_ofs_reg` have no effect on any output.
- R3: With `in_sub`=1 the offset is subtracted from the base, otherwise added (base 0x200 minus 12 gives 0x1F4).
- R4: Pre-index without update (`in_post`=0, `in_update`=0): `out_addr` = base ± offset, `out_new_base` = base, `out_wb_en` = 0.
- R5: Pre-index with update (`in_post`=0, `in_update`=1): `out_addr` and `out_new_base` both equal base ± offset and `out_wb_en` = 1.
- R6: Post-index (`in_post`=1): `out_addr` = base, `out_new_base` = base ± offset, `out_wb_en` = 1 whatever `in_update` is.
- R7: Address sums and differences wrap modulo 2^32 (0xFFFFFFF0 + 0x20 gives 0x10; 0 − 1 gives 0xFFFFFFFF).
- R8: After reset `out_valid` is 0 and `in_ready` is 1.
- R9: An accepted request shows its result with `out_valid`=1 on the next cycle; `in_ready` = !`out_valid` || `out_ready`.
- R10: While `out_valid`=1 and `out_ready`=0 the outputs hold their values and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_base | input | 32 | Base register value |
| in_imm | input | 12 | Unsigned immediate offset |
| in_ofs_reg | input | 32 | Register offset value |
| in_shamt | input | 5 | Left shift applied to the register offset |
| in_sub | input | 1 | 1 subtracts the offset, 0 adds it |
| in_use_reg | input | 1 | 1 selects the shifted register offset, 0 the immediate |
| in_post | input | 1 | 1 selects post-index |
| in_update | input | 1 | Base replacement for pre-index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Memory access address |
| out_new_base | output | 32 | Value for the base register |
| out_wb_en | output | 1 | Base register should be written |

## Verification
On every cycle the assertions check the handshake rules: ready follows the output occupancy, accepted requests appear one cycle later, and stalled results hold still. They also check the indexing relations that tie the outputs to the sampled base, namely the post-index address, the kept base for plain pre-index, and the equal address and base for pre-index with update. The offset arithmetic, meaning zero-extension, shifting, subtraction and wraparound, is only shown by the bench. The bench compares every result against a reference computed from its inputs, over directed corner values and constrained random requests, including under back-pressure.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IMM_W  = 12;
  localparam int unsigned SH_W   = 5;

  typedef enum logic [1:0] {
    IDX_PRE_KEEP = 2'd0,
    IDX_PRE_UPD  = 2'd1,
    IDX_POST     = 2'd2
  } idx_mode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] new_base;
    logic              wb_en;
  } agu_result_t;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int unsigned AW   = 32,
  parameter int unsigned IMMW = 12,
  parameter int unsigned SHW  = 5
) (
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   reg_val,
  input  logic [SHW-1:0]  shamt,
  input  logic            use_reg,
  output logic [AW-1:0]   offset
);
  localparam int unsigned STAGES = SHW;

  logic [AW-1:0] stage [STAGES+1];
  logic [AW-1:0] imm_ext;

  assign stage[0] = reg_val;

  // logarithmic left shifter: stage k moves by 2^k when shamt[k] is set
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_shift
      localparam int unsigned DIST = 1 << k;
      if (DIST < AW) begin : g_live
        assign stage[k+1] = shamt[k] ? {stage[k][AW-1-DIST:0], {DIST{1'b0}}} : stage[k];
      end else begin : g_flush
        assign stage[k+1] = shamt[k] ? '0 : stage[k];
      end
    end
  endgenerate

  assign imm_ext = {{(AW-IMMW){1'b0}}, imm};
  assign offset  = use_reg ? stage[STAGES] : imm_ext;
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          sub,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] operand;
  logic [AW-1:0] carry_in;

  // single adder: subtraction as base + ~offset + 1, result truncated (wraps)
  assign operand  = offset ^ {AW{sub}};
  assign carry_in = {{(AW-1){1'b0}}, sub};
  assign sum      = base + operand + carry_in;
endmodule

// File: rtl/agu_index.sv
module agu_index
  import lsu_agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] sum,
  input  logic          post,
  input  logic          update,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] new_base,
  output logic          wb_en
);
  idx_mode_e mode;

  always_comb begin
    if (post)        mode = IDX_POST;
    else if (update) mode = IDX_PRE_UPD;
    else             mode = IDX_PRE_KEEP;
  end

  always_comb begin
    unique case (mode)
      IDX_POST: begin
        addr     = base;
        new_base = sum;
        wb_en    = 1'b1;
      end
      IDX_PRE_UPD: begin
        addr     = sum;
        new_base = sum;
        wb_en    = 1'b1;
      end
      default: begin
        addr     = sum;
        new_base = base;
        wb_en    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [ADDR_W-1:0] in_ofs_reg,
  input  logic [SH_W-1:0]   in_shamt,
  input  logic              in_sub,
  input  logic              in_use_reg,
  input  logic              in_post,
  input  logic              in_update,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_new_base,
  output logic              out_wb_en
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  agu_result_t       comb_res;
  agu_result_t       held_res;
  logic              held_valid;
  logic              take_in;

  agu_offset #(.AW(ADDR_W), .IMMW(IMM_W), .SHW(SH_W)) u_offset (
    .imm     (in_imm),
    .reg_val (in_ofs_reg),
    .shamt   (in_shamt),
    .use_reg (in_use_reg),
    .offset  (offset)
  );

  agu_addsub #(.AW(ADDR_W)) u_addsub (
    .base   (in_base),
    .offset (offset),
    .sub    (in_sub),
    .sum    (sum)
  );

  agu_index #(.AW(ADDR_W)) u_index (
    .base     (in_base),
    .sum      (sum),
    .post     (in_post),
    .update   (in_update),
    .addr     (comb_res.addr),
    .new_base (comb_res.new_base),
    .wb_en    (comb_res.wb_en)
  );

  assign in_ready = !held_valid || out_ready;
  assign take_in  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_res   <= '0;
    end else begin
      if (in_ready) held_valid <= in_valid;
      if (take_in)  held_res   <= comb_res;
    end
  end

  assign out_valid    = held_valid;
  assign out_addr     = held_res.addr;
  assign out_new_base = held_res.new_base;
  assign out_wb_en    = held_res.wb_en;
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk
  import lsu_agu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_base,
  input logic              in_post,
  input logic              in_update,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ADDR_W-1:0] out_new_base,
  input logic              out_wb_en
);
  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_new_base) && $stable(out_wb_en)));

  assert_post_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_post) |=> (out_addr == $past(in_base) && out_wb_en));

  assert_pre_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_post && !in_update) |=>
      (out_new_base == $past(in_base) && !out_wb_en));

  assert_pre_upd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_post && in_update) |=>
      (out_addr == out_new_base && out_wb_en));

  always_comb begin
    if (!rst_n) assert_reset_empty_R8: assert (!out_valid);
  end
endmodule

bind lsu_addr_gen lsu_addr_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_base      (in_base),
  .in_post      (in_post),
  .in_update    (in_update),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_addr     (out_addr),
  .out_new_base (out_new_base),
  .out_wb_en    (out_wb_en)
);

// File: tb/test_lsu_addr_gen.sv
`timescale 1ns/1ps
module test_lsu_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_base = '0;
  logic [11:0] in_imm = '0;
  logic [31:0] in_ofs_reg = '0;
  logic [4:0]  in_shamt = '0;
  logic        in_sub = 1'b0;
  logic        in_use_reg = 1'b0;
  logic        in_post = 1'b0;
  logic        in_update = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [31:0] out_new_base;
  logic        out_wb_en;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned cycles   = 0;
  bit          done     = 1'b0;

  always #5 clk = ~clk;

  lsu_addr_gen i_lsu_addr_gen (.*);

  function automatic logic [31:0] ref_sum(logic [31:0] b, logic [11:0] imm, logic [31:0] r,
                                          logic [4:0] sh, logic sub, logic use_reg);
    logic [31:0] o;
    o = use_reg ? (r << sh) : {20'd0, imm};
    return sub ? b - o : b + o;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic set_req(logic [31:0] b, logic [11:0] imm, logic [31:0] r, logic [4:0] sh,
                         logic sub, logic use_reg, logic post, logic upd);
    in_base = b; in_imm = imm; in_ofs_reg = r; in_shamt = sh;
    in_sub = sub; in_use_reg = use_reg; in_post = post; in_update = upd;
  endtask

  task automatic check_result(string tag);
    logic [31:0] s, ea, eb;
    logic ew;
    s  = ref_sum(in_base, in_imm, in_ofs_reg, in_shamt, in_sub, in_use_reg);
    ea = in_post ? in_base : s;
    eb = (in_post || in_update) ? s : in_base;
    ew = in_post || in_update;
    check(out_valid == 1'b1, {tag, " R9 valid"}, 32'(out_valid), 32'd1);
    check(out_addr == ea, {tag, " addr"}, out_addr, ea);
    check(out_new_base == eb, {tag, " new_base"}, out_new_base, eb);
    check(out_wb_en == ew, {tag, " wb_en"}, 32'(out_wb_en), 32'(ew));
  endtask

  // one request with the consumer ready; result checked after the accepting edge
  task automatic send(logic [31:0] b, logic [11:0] imm, logic [31:0] r, logic [4:0] sh,
                      logic sub, logic use_reg, logic post, logic upd, string tag);
    @(negedge clk);
    set_req(b, imm, r, sh, sub, use_reg, post, upd);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(tag);
  endtask

  task automatic expect_val(logic [31:0] act, logic [31:0] exp, string tag);
    check(act == exp, tag, act, exp);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fails++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] keep_addr, keep_nb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R8 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after reset", 32'(out_valid), 32'd0);

    // R3 + R4: pre-index keep, subtract 12
    send(32'h200, 12'd12, 32'h0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3/R4 sub12");
    expect_val(out_addr, 32'h1F4, "R3 0x200-12");
    expect_val(out_new_base, 32'h200, "R4 base kept");
    // R5: pre-index update, subtract 4
    send(32'h200, 12'd4, 32'h0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 pre upd");
    expect_val(out_addr, 32'h1FC, "R5 addr");
    expect_val(out_new_base, 32'h1FC, "R5 new_base");
    // R6: post-index add 12, update bit low still writes back
    send(32'h200, 12'd12, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 post");
    expect_val(out_addr, 32'h200, "R6 addr");
    expect_val(out_new_base, 32'h20C, "R6 new_base");
    expect_val(32'(out_wb_en), 32'd1, "R6 wb_en");
    // R2: register 3 shifted by 2 adds 12
    send(32'h200, 12'd0, 32'd3, 5'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R2 shift");
    expect_val(out_new_base, 32'h20C, "R2 3<<2");
    // R2: shift 31 keeps low bits only
    send(32'h0, 12'd0, 32'h3, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, "R2 sh31");
    expect_val(out_addr, 32'h8000_0000, "R2 3<<31");
    // R2: immediate form ignores register and shift
    send(32'h1000, 12'd8, 32'hDEAD_BEEF, 5'd17, 1'b0, 1'b0, 1'b0, 1'b0, "R2 ignore");
    expect_val(out_addr, 32'h1008, "R2 imm ignores reg");
    // R1: immediate zero-extended
    send(32'h0, 12'hFFF, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 zext");
    expect_val(out_addr, 32'hFFF, "R1 0xFFF");
    // R7: wrap
    send(32'hFFFF_FFF0, 12'h20, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 wrap up");
    expect_val(out_addr, 32'h10, "R7 up");
    send(32'h0, 12'd1, 32'h0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 wrap down");
    expect_val(out_new_base, 32'hFFFF_FFFF, "R7 down");

    // R10: back-pressure holds result, R9: ready low while full
    @(negedge clk);
    out_ready = 1'b0;
    set_req(32'h4000, 12'd16, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    in_valid = 1'b1;
    @(negedge clk);
    keep_addr = out_addr;
    keep_nb   = out_new_base;
    expect_val(keep_addr, 32'h4010, "R10 first result");
    set_req(32'h8000, 12'd4, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(in_ready == 1'b0, "R9 ready low when stalled", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    expect_val(out_addr, keep_addr, "R10 addr held");
    expect_val(out_new_base, keep_nb, "R10 base held");
    expect_val(32'(out_valid), 32'd1, "R10 valid held");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_val(out_addr, 32'h8000, "R9 next taken on drain edge");
    expect_val(out_new_base, 32'h8004, "R9 next new_base");
    @(negedge clk);
    expect_val(32'(out_valid), 32'd0, "R9 empty after drain");

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] b;
      b = $urandom();
      if (i % 7 == 0) b = 32'hFFFF_F000 | b[11:0];
      send(b, 12'($urandom()), $urandom(), 5'($urandom()), 1'($urandom()),
           1'($urandom()), 1'($urandom()), 1'($urandom()), "R1-7 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule